// File: doc/BRIEF.md
# UART Receive Status and Interrupt Unit

This block sits between an asynchronous serial input and a CPU register port. A receiver oversamples the line at 16 times the bit rate and assembles 8-bit frames. It checks even parity and the stop bit according to the selected mode. When the stop bit is sampled, the receive data register, the parity error flag, the overrun flag, the framing error flag and the receive-full flag all update in the same clock cycle.

A transmit holding register with an empty flag is also part of the block. The shifter that drains this register lies outside the block and is represented by a single take strobe. Two interrupt lines are driven from the flags: one for receive and one for transmit.

The CPU controls the block with three strobes that share one write-data bus:
- a receive-data read strobe,
- a control write, whose bit 0 is the error-clear bit,
- a transmit-holding write.

Top module: `uart_stat_unit`

## Requirements
- R1: After reset, status_o reads 5'b00001, rx_irq_o is 0 and tx_irq_o is 1. The status_o bit positions are [4] parity error, [3] overrun, [2] framing error, [1] receive-full and [0] transmit-empty.
- R2: The frame format is fixed by the mode. The line idles high. A frame is a low start bit, then 8 data bits LSB first, then one stop bit. In mode 0 only, an extra parity bit sits between the data bits and the stop bit. When the stop bit is sampled, the byte is loaded into rx_data_o and receive-full is set. Mode value 3 behaves like mode 2.
- R3: The parity, overrun and framing flags stay set until a control write with wdata_i[0]=0 clears them. A control write with wdata_i[0]=1 leaves them unchanged.
- R4: A pulse on rx_rd_i clears receive-full. If a frame completes in the same cycle, the flag remains set.
- R5: In mode 0, the parity error flag is set when the data bits and the parity bit together hold an odd number of ones (even parity expected). The flag is never set in modes 1 and 2.
- R6: A low stop bit sets the framing error flag in modes 0 and 1. It never sets the flag in mode 2.
- R7: If a frame completes while receive-full is still set, the overrun flag is set, rx_data_o keeps the earlier byte, and the new byte is dropped.
- R8: A start bit that is no longer low at its midpoint is rejected. A low glitch shorter than half a bit therefore changes no flag, and the next frame is received correctly.
- R9: Transmit-empty is set after reset and is cleared by tx_wr_i, which loads wdata_i into tx_data_o. It is set again by tx_take_i.
- R10: rx_irq_o is high exactly when any of parity error, overrun, framing error or receive-full is set. tx_irq_o follows transmit-empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial receive line |
| mode_i | input | 2 | Frame mode select |
| rx_rd_i | input | 1 | CPU read strobe for the receive data register |
| ctrl_wr_i | input | 1 | CPU control write; bit 0 of wdata_i is the error-clear bit |
| tx_wr_i | input | 1 | CPU write strobe for the transmit holding register |
| tx_take_i | input | 1 | Shifter took the holding register |
| wdata_i | input | 8 | CPU write data |
| rx_data_o | output | 8 | Receive data register |
| tx_data_o | output | 8 | Transmit holding register |
| status_o | output | 5 | Flags {pe, ore, fre, rdrf, tdre} |
| rx_irq_o | output | 1 | Receive interrupt |
| tx_irq_o | output | 1 | Transmit interrupt |

## Verification
The bench drives bad-parity and low-stop frames in every mode:
- A design that checks parity or framing in the wrong mode raises a flag that must stay clear.
- A design that samples the stop bit one bit early misreads the data.

Back-to-back frames with no read in between force overruns. A design that overwrites the held byte, or that skips the overrun flag, shows the wrong data or status. Control writes with bit 0 set catch a clear on the wrong polarity. A short low glitch catches a receiver that starts a frame on a bare falling edge: such a receiver would load a bogus byte and then misalign the frame that follows.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam logic [1:0] MODE_PAR  = 2'd0;
  localparam logic [1:0] MODE_STOP = 2'd1;
  localparam int ST_PE   = 4;
  localparam int ST_ORE  = 3;
  localparam int ST_FRE  = 2;
  localparam int ST_RDRF = 1;
  localparam int ST_TDRE = 0;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/uart_baud_div.sv
module uart_baud_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_stat_pkg::*;
#(
  parameter int W   = 8,
  parameter int OSR = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         rxd_i,
  input  logic [1:0]   mode_i,
  output logic         done_o,
  output logic [W-1:0] data_o,
  output logic         par_err_o,
  output logic         frm_err_o
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2 - 1;
  localparam int BW  = (W > 1) ? $clog2(W) : 1;

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     st_q;
  logic [CW-1:0] os_q;
  logic [BW-1:0] bit_q;
  logic [W-1:0]  sh_q;
  logic          par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else sync_q <= {sync_q[0], rxd_i};
  end
  assign rx_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= RX_IDLE;
      os_q      <= '0;
      bit_q     <= '0;
      sh_q      <= '0;
      par_q     <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        RX_IDLE: if (!rx_s) begin
          st_q <= RX_START;
          os_q <= '0;
        end
        RX_START: if (tick_i) begin
          if (os_q == CW'(MID)) begin
            os_q  <= '0;
            bit_q <= '0;
            st_q  <= rx_s ? RX_IDLE : RX_DATA;
          end else os_q <= os_q + 1'b1;
        end
        RX_DATA: if (tick_i) begin
          if (os_q == CW'(OSR - 1)) begin
            os_q <= '0;
            sh_q <= {rx_s, sh_q[W-1:1]};
            if (bit_q == BW'(W - 1)) st_q <= (mode_i == MODE_PAR) ? RX_PAR : RX_STOP;
            else bit_q <= bit_q + 1'b1;
          end else os_q <= os_q + 1'b1;
        end
        RX_PAR: if (tick_i) begin
          if (os_q == CW'(OSR - 1)) begin
            os_q  <= '0;
            par_q <= rx_s;
            st_q  <= RX_STOP;
          end else os_q <= os_q + 1'b1;
        end
        RX_STOP: if (tick_i) begin
          if (os_q == CW'(OSR - 1)) begin
            os_q      <= '0;
            done_o    <= 1'b1;
            data_o    <= sh_q;
            par_err_o <= (mode_i == MODE_PAR) && ((^sh_q) ^ par_q);
            frm_err_o <= !mode_i[1] && !rx_s;
            st_q      <= rx_s ? RX_IDLE : RX_HOLD;
          end else os_q <= os_q + 1'b1;
        end
        RX_HOLD: if (rx_s) st_q <= RX_IDLE;
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  p_start_reject_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == RX_START && tick_i && os_q == CW'(MID) && rx_s) |=> (st_q == RX_IDLE && !done_o));
  p_one_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/uart_flag_regs.sv
module uart_flag_regs
  import uart_stat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic         done_i,
  input  logic [W-1:0] data_i,
  input  logic         par_err_i,
  input  logic         frm_err_i,
  input  logic         rx_rd_i,
  input  logic         ctrl_wr_i,
  input  logic         tx_wr_i,
  input  logic         tx_take_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rx_data_o,
  output logic [W-1:0] tx_data_o,
  output logic [4:0]   status_o
);
  logic pe_q, ore_q, fre_q, rdrf_q, tdre_q;
  logic err_clr;

  assign err_clr = ctrl_wr_i && !wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pe_q      <= 1'b0;
      ore_q     <= 1'b0;
      fre_q     <= 1'b0;
      rdrf_q    <= 1'b0;
      rx_data_o <= '0;
    end else begin
      pe_q  <= (pe_q  && !err_clr) || (done_i && par_err_i);
      fre_q <= (fre_q && !err_clr) || (done_i && frm_err_i);
      ore_q <= (ore_q && !err_clr) || (done_i && rdrf_q);
      if (done_i) begin
        rdrf_q <= 1'b1;
        if (!rdrf_q) rx_data_o <= data_i;
      end else if (rx_rd_i) rdrf_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdre_q    <= 1'b1;
      tx_data_o <= '0;
    end else if (tx_wr_i) begin
      tdre_q    <= 1'b0;
      tx_data_o <= wdata_i;
    end else if (tx_take_i) tdre_q <= 1'b1;
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_PE]   = pe_q;
    status_o[ST_ORE]  = ore_q;
    status_o[ST_FRE]  = fre_q;
    status_o[ST_RDRF] = rdrf_q;
    status_o[ST_TDRE] = tdre_q;
  end

  p_err_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pe_q || ore_q || fre_q) && !err_clr) |=> (status_o[ST_PE] >= $past(pe_q)
      && status_o[ST_ORE] >= $past(ore_q) && status_o[ST_FRE] >= $past(fre_q)));
  p_rdrf_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_i && !done_i) |=> !rdrf_q);
  p_no_par_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_PAR && !pe_q) |=> !pe_q);
  p_no_frm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && !fre_q) |=> !fre_q);
  p_ovr_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rdrf_q) |=> (ore_q && $stable(rx_data_o)));
  p_tdre_wr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_i |=> (!tdre_q && tx_data_o == $past(wdata_i)));
endmodule

// File: rtl/uart_stat_unit.sv
module uart_stat_unit
  import uart_stat_pkg::*;
#(
  parameter int W   = 8,
  parameter int OSR = 16,
  parameter int DIV = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rxd_i,
  input  logic [1:0]   mode_i,
  input  logic         rx_rd_i,
  input  logic         ctrl_wr_i,
  input  logic         tx_wr_i,
  input  logic         tx_take_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rx_data_o,
  output logic [W-1:0] tx_data_o,
  output logic [4:0]   status_o,
  output logic         rx_irq_o,
  output logic         tx_irq_o
);
  logic         tick;
  logic         done;
  logic [W-1:0] rx_byte;
  logic         par_err, frm_err;

  uart_baud_div #(.DIV(DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  uart_rx_core #(.W(W), .OSR(OSR)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rxd_i(rxd_i),
    .mode_i(mode_i), .done_o(done), .data_o(rx_byte),
    .par_err_o(par_err), .frm_err_o(frm_err)
  );

  uart_flag_regs #(.W(W)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .done_i(done),
    .data_i(rx_byte), .par_err_i(par_err), .frm_err_i(frm_err),
    .rx_rd_i(rx_rd_i), .ctrl_wr_i(ctrl_wr_i), .tx_wr_i(tx_wr_i),
    .tx_take_i(tx_take_i), .wdata_i(wdata_i), .rx_data_o(rx_data_o),
    .tx_data_o(tx_data_o), .status_o(status_o)
  );

  assign rx_irq_o = |status_o[4:1];
  assign tx_irq_o = status_o[ST_TDRE];

  p_irq_rx_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && $past(rst_ni)) |=> rx_irq_o);
endmodule

// File: tb/sim_uart_stat_unit.sv
`timescale 1ns/1ps
module sim_uart_stat_unit;
  localparam int BITCLK = 64;

  logic       clk_i = 0;
  logic       rst_ni = 0;
  logic       rxd_i = 1;
  logic [1:0] mode_i = 0;
  logic       rx_rd_i = 0, ctrl_wr_i = 0, tx_wr_i = 0, tx_take_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rx_data_o, tx_data_o;
  logic [4:0] status_o;
  logic       rx_irq_o, tx_irq_o;

  int total = 0, bad = 0;
  logic [4:0] exp_st;
  logic [7:0] exp_data;

  always #10 clk_i = ~clk_i;

  uart_stat_unit u0 (
    .clk_i, .rst_ni, .rxd_i, .mode_i, .rx_rd_i, .ctrl_wr_i, .tx_wr_i,
    .tx_take_i, .wdata_i, .rx_data_o, .tx_data_o, .status_o, .rx_irq_o, .tx_irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] next_stat(input logic [4:0] s, input logic [1:0] m,
                                           input logic bp, input logic bs);
    logic [4:0] n = s;
    if (s[1]) n[3] = 1'b1;
    if (m == 2'd0 && bp) n[4] = 1'b1;
    if (!m[1] && bs) n[2] = 1'b1;
    n[1] = 1'b1;
    return n;
  endfunction

  task automatic send(input logic [7:0] d, input logic [1:0] m, input logic bp, input logic bs);
    @(negedge clk_i);
    mode_i = m;
    rxd_i = 0; repeat (BITCLK) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin rxd_i = d[i]; repeat (BITCLK) @(negedge clk_i); end
    if (m == 2'd0) begin rxd_i = (^d) ^ bp; repeat (BITCLK) @(negedge clk_i); end
    rxd_i = !bs; repeat (BITCLK) @(negedge clk_i);
    rxd_i = 1; repeat (BITCLK/2) @(negedge clk_i);
    if (!exp_st[1]) exp_data = d;
    exp_st = next_stat(exp_st, m, bp, bs);
  endtask

  task automatic cpu_rd();
    @(negedge clk_i); rx_rd_i = 1; @(negedge clk_i); rx_rd_i = 0;
    exp_st[1] = 0;
  endtask

  task automatic cpu_ctrl(input logic [7:0] v);
    @(negedge clk_i); ctrl_wr_i = 1; wdata_i = v; @(negedge clk_i); ctrl_wr_i = 0;
    if (!v[0]) exp_st[4:2] = 3'b000;
  endtask

  task automatic check_all(input string tag);
    @(negedge clk_i);
    chk({tag, " R2/R5/R6/R7 status"}, status_o, exp_st);
    chk({tag, " R10 rx_irq"}, rx_irq_o, |exp_st[4:1]);
    chk({tag, " R10 tx_irq"}, tx_irq_o, exp_st[0]);
    if (exp_st[1] && exp_st[4:2] == 3'b000) chk({tag, " R2 data"}, rx_data_o, exp_data);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog R0 act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    exp_st = 5'b00001; exp_data = 0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset status", status_o, 5'b00001);
    chk("R1 reset rx_irq", rx_irq_o, 0);
    chk("R1 reset tx_irq", tx_irq_o, 1);
    rst_ni = 1;
    repeat (4) @(negedge clk_i);

    // R9 transmit holding
    @(negedge clk_i); tx_wr_i = 1; wdata_i = 8'hA5; @(negedge clk_i); tx_wr_i = 0;
    chk("R9 tdre after write", status_o[0], 0);
    chk("R9 tx data", tx_data_o, 8'hA5);
    chk("R10 tx_irq low", tx_irq_o, 0);
    @(negedge clk_i); tx_take_i = 1; @(negedge clk_i); tx_take_i = 0;
    chk("R9 tdre after take", status_o[0], 1);

    // directed frames per mode
    send(8'h3C, 0, 0, 0); check_all("d0");
    chk("R4 data before read", rx_data_o, 8'h3C);
    cpu_rd(); check_all("R4 read");
    send(8'h81, 0, 1, 0); check_all("R5 parity m0");
    cpu_ctrl(8'h01); check_all("R3 ctrl bit0=1 keeps");
    cpu_rd(); cpu_ctrl(8'h00); check_all("R3 clear");
    send(8'h55, 1, 1, 0); check_all("R5 m1 no parity");
    cpu_rd();
    send(8'h66, 1, 0, 1); check_all("R6 m1 frame err");
    cpu_rd(); cpu_ctrl(8'h00);
    send(8'h99, 2, 0, 1); check_all("R6 m2 no frame check");
    send(8'h11, 2, 0, 0); check_all("R7 overrun");
    chk("R7 kept byte", rx_data_o, 8'h99);
    cpu_rd(); cpu_ctrl(8'h00); check_all("R3 post clear");

    // R8 glitch
    @(negedge clk_i); rxd_i = 0; repeat (20) @(negedge clk_i); rxd_i = 1;
    repeat (200) @(negedge clk_i);
    check_all("R8 glitch");
    send(8'hC3, 1, 0, 0); check_all("R8 after glitch");
    cpu_rd();

    // constrained random
    for (int i = 0; i < 50; i++) begin
      logic [1:0] m = 2'($urandom % 3);
      logic [7:0] d = 8'($urandom);
      logic bp = (m == 0) && ($urandom % 5 == 0);
      logic bs = ($urandom % 6 == 0);
      if ($urandom % 3 != 0 && exp_st[1]) cpu_rd();
      if ($urandom % 4 == 0) cpu_ctrl(8'($urandom));
      send(d, m, bp, bs);
      check_all("rnd");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule